// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block sits in a host bridge and steers each CPU access in the legacy area below 1 MiB. Accesses land either on system DRAM or on the PCI bus. Seven attribute bytes in configuration space split the 0xC0000–0xFFFFF range into thirteen regions: one 64 KiB BIOS segment and twelve 16 KiB expansion segments. Each region has its own read-enable and write-enable bit for DRAM. A separate control byte for system-management RAM decides where the 0xA0000–0xBFFFF window goes. The decision depends on whether the CPU is in system-management mode.

Software programs the registers through a byte-wide configuration write/read port. The CPU side presents an address, a write flag and an SMM flag with a valid strobe. The block answers one clock later with a target code: none, DRAM or PCI. A write that lands on an attribute byte or on the SMRAM byte posts a refresh strobe. The decode state seen by CPU accesses is rebuilt from that strobe one cycle later.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset every attribute byte reads 0x00 and the SMRAM control byte reads 0x02, so every region and the 0xA0000–0xBFFFF window decode to PCI for both SMM and non-SMM accesses.
- R2: Configuration offsets 0x59–0x5F (attribute bytes) and 0x72 (SMRAM control) store all 8 written bits and read them back. Read data appears on `cfgRdData` one cycle after `cfgRdEn`. Any other offset reads 0x00, and a write to it changes no register and no decode.
- R3: Region 0 is 0xF0000–0xFFFFF and takes the high nibble of offset 0x59. Region i (1..12) is 0xC0000 + (i−1)·0x4000 through 0x3FFF above that. It takes its nibble from offset 0x59 + ceil(i/2): the low nibble when i is odd, the high nibble when i is even.
- R4: Within a region nibble, bit 0 sends reads to DRAM and bit 1 sends writes to DRAM. An access whose type is not enabled goes to PCI. Nibble bits 2–3 and the low nibble of 0x59 have no effect.
- R5: In the 0xA0000–0xBFFFF window, a non-SMM access goes to DRAM when bit 6 (open) of the SMRAM byte is set, and to PCI when it is clear.
- R6: In the 0xA0000–0xBFFFF window, an SMM access goes to DRAM when bit 3 (SMRAM enable) is set. Otherwise it follows the bit-6 rule of R5. Other SMRAM bits have no effect.
- R7: Accesses to the thirteen attribute regions decode the same way whether or not the SMM flag is set.
- R8: The target code is 0 for none, 1 for DRAM and 2 for PCI. It is none when no access is valid, and for any address outside 0xA0000–0xFFFFF, including addresses whose bits above bit 19 are non-zero.
- R9: The target for an access presented in a cycle is registered at the next clock edge. A configuration write committed at edge E is seen by accesses registered at edge E+2 or later. An access registered at E+1 still decodes with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgRdEn | input | 1 | Configuration byte read strobe |
| cfgAddr | input | 8 | Configuration offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data, one cycle after cfgRdEn |
| cpuValid | input | 1 | CPU access present this cycle |
| cpuAddr | input | 32 | CPU byte address |
| cpuWrite | input | 1 | 1 for a write access, 0 for a read |
| cpuSmm | input | 1 | Access is made in system-management mode |
| tgtSel | output | 2 | Registered target: 0 none, 1 DRAM, 2 PCI |

## Verification
The routing target is due one edge after the access is driven. Configuration read data is also due one edge after its strobe. Both are sampled on the falling edge that follows that rising edge. A register write affects routing only from the second edge after it commits. The sweeps therefore leave one idle cycle between a write and the first dependent access. One dedicated sequence drives an access in the very cycle after a write, checks the stale result at the first sample and the new result at the next. Expected targets come from a bench model of the register bytes and the address arithmetic of R3–R8. That model covers both ends of every region, every SMRAM bit combination and every access type.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  // Target code driven on tgtSel
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_PCI  = 2'd2
  } tgt_e;

  // Strobes from the register control to the routing datapath
  typedef struct packed {
    logic refreshAttr;
    logic refreshSmram;
  } refresh_s;

endpackage

// File: rtl/lwd_cfg_ctrl.sv
module lwd_cfg_ctrl
  import lwd_pkg::*;
#(
  parameter int unsigned       CFG_AW      = 8,
  parameter int unsigned       NUM_REGIONS = 13,
  parameter logic [CFG_AW-1:0] ATTR_BASE   = 'h59,
  parameter logic [CFG_AW-1:0] SMRAM_OFF   = 'h72,
  parameter logic [7:0]        SMRAM_RESET = 8'h02,
  parameter int unsigned       DOPEN_BIT   = 6,
  parameter int unsigned       GSMRAME_BIT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgRdEn,
  input  logic [CFG_AW-1:0]      cfgAddr,
  input  logic [7:0]             cfgWrData,
  output logic [7:0]             cfgRdData,
  output refresh_s               refresh,
  output logic [NUM_REGIONS-1:0] regionRd,
  output logic [NUM_REGIONS-1:0] regionWr,
  output logic                   openBit,
  output logic                   smmBit
);

  // Region 0 owns one byte alone; the rest pack two per byte
  localparam int unsigned NUM_ATTR = (NUM_REGIONS + 2) / 2;
  localparam int unsigned IDX_W    = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1;

  logic [7:0]          attrQ [NUM_ATTR];
  logic [7:0]          smramQ;
  logic [CFG_AW-1:0]   cfgOff;
  logic [IDX_W-1:0]    attrIdx;
  logic                attrHit;
  logic                smramHit;
  logic [NUM_ATTR*8-1:0] attrFlat;

  assign cfgOff   = cfgAddr - ATTR_BASE;
  assign attrHit  = cfgOff < CFG_AW'(NUM_ATTR);
  assign attrIdx  = cfgOff[IDX_W-1:0];
  assign smramHit = (cfgAddr == SMRAM_OFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ATTR; k++) attrQ[k] <= '0;
      smramQ    <= SMRAM_RESET;
      refresh   <= '0;
      cfgRdData <= '0;
    end else begin
      if (cfgWrEn && attrHit)  attrQ[attrIdx] <= cfgWrData;
      if (cfgWrEn && smramHit) smramQ <= cfgWrData;
      refresh.refreshAttr  <= cfgWrEn && attrHit;
      refresh.refreshSmram <= cfgWrEn && smramHit;
      if (cfgRdEn) begin
        if (attrHit)       cfgRdData <= attrQ[attrIdx];
        else if (smramHit) cfgRdData <= smramQ;
        else               cfgRdData <= 8'h00;
      end
    end
  end

  for (genvar b = 0; b < NUM_ATTR; b++) begin : g_flat
    assign attrFlat[b*8 +: 8] = attrQ[b];
  end

  // Nibble selection per region
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_nib
    localparam int unsigned BYTE_IDX = (r + 1) / 2;
    localparam bit          USE_HIGH = (r == 0) || (r % 2 == 0);
    if (USE_HIGH) begin : g_hi
      assign regionRd[r] = attrQ[BYTE_IDX][4];
      assign regionWr[r] = attrQ[BYTE_IDX][5];
    end else begin : g_lo
      assign regionRd[r] = attrQ[BYTE_IDX][0];
      assign regionWr[r] = attrQ[BYTE_IDX][1];
    end
  end

  assign openBit = smramQ[DOPEN_BIT];
  assign smmBit  = smramQ[GSMRAME_BIT];

  // R1: SMRAM byte leaves reset at its defined value
  a_r1_smram_reset : assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> smramQ == SMRAM_RESET);

  // R2: writes to offsets outside the map change nothing
  a_r2_unmapped_ignored : assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !attrHit && !smramHit) |=> ($stable(smramQ) && $stable(attrFlat)));

  // R9: a mapped write posts a refresh strobe on the next cycle
  a_r9_refresh_posted : assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (attrHit || smramHit)) |=> (refresh.refreshAttr || refresh.refreshSmram));

endmodule

// File: rtl/lwd_route_dp.sv
module lwd_route_dp
  import lwd_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       NUM_REGIONS   = 13,
  parameter int unsigned       SEG_SHIFT     = 14,
  parameter logic [ADDR_W-1:0] EXP_BASE      = 'hC0000,
  parameter logic [ADDR_W-1:0] BIOS_BASE     = 'hF0000,
  parameter logic [ADDR_W-1:0] BIOS_SIZE     = 'h10000,
  parameter logic [ADDR_W-1:0] SMRAM_BASE    = 'hA0000,
  parameter logic [ADDR_W-1:0] SMRAM_SIZE    = 'h20000,
  parameter bit                OPEN_RESET    = 1'b0,
  parameter bit                SMMEN_RESET   = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  refresh_s               refresh,
  input  logic [NUM_REGIONS-1:0] regionRd,
  input  logic [NUM_REGIONS-1:0] regionWr,
  input  logic                   openBit,
  input  logic                   smmBit,
  input  logic                   cpuValid,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuWrite,
  input  logic                   cpuSmm,
  output tgt_e                   tgtSel
);

  localparam int unsigned       REG_W      = $clog2(NUM_REGIONS);
  localparam logic [ADDR_W-1:0] BIOS_LAST  = BIOS_BASE + BIOS_SIZE - 1;
  localparam logic [ADDR_W-1:0] SMRAM_LAST = SMRAM_BASE + SMRAM_SIZE - 1;
  localparam logic [ADDR_W-1:0] EXP_LIMIT  =
    EXP_BASE + (ADDR_W'(NUM_REGIONS - 1) << SEG_SHIFT);

  logic [NUM_REGIONS-1:0] rdEnQ, wrEnQ;
  logic                   openQ, smmEnQ;
  logic                   smramWin, biosWin, expWin, anyWin;
  logic [ADDR_W-1:0]      expOff;
  logic [REG_W-1:0]       regionIdx;
  logic                   allowDram;
  tgt_e                   tgtD;

  // Shadow decode state, rebuilt on refresh strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdEnQ  <= '0;
      wrEnQ  <= '0;
      openQ  <= OPEN_RESET;
      smmEnQ <= SMMEN_RESET;
    end else begin
      if (refresh.refreshAttr) begin
        rdEnQ <= regionRd;
        wrEnQ <= regionWr;
      end
      if (refresh.refreshSmram) begin
        openQ  <= openBit;
        smmEnQ <= smmBit;
      end
    end
  end

  // Window classification
  assign smramWin = (cpuAddr >= SMRAM_BASE) && (cpuAddr <= SMRAM_LAST);
  assign biosWin  = (cpuAddr >= BIOS_BASE)  && (cpuAddr <= BIOS_LAST);
  assign expWin   = (cpuAddr >= EXP_BASE)   && (cpuAddr <  EXP_LIMIT);
  assign anyWin   = smramWin || biosWin || expWin;
  assign expOff   = cpuAddr - EXP_BASE;

  always_comb begin
    if (biosWin) regionIdx = '0;
    else         regionIdx = REG_W'(expOff >> SEG_SHIFT) + REG_W'(1);
  end

  assign allowDram = cpuWrite ? wrEnQ[regionIdx] : rdEnQ[regionIdx];

  always_comb begin
    tgtD = TGT_NONE;
    if (cpuValid) begin
      if (smramWin)
        tgtD = (openQ || (cpuSmm && smmEnQ)) ? TGT_DRAM : TGT_PCI;
      else if (biosWin || expWin)
        tgtD = allowDram ? TGT_DRAM : TGT_PCI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tgtSel <= TGT_NONE;
    else       tgtSel <= tgtD;
  end

  // R8: no access means no target
  a_r8_idle_none : assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |=> tgtSel == TGT_NONE);

  // R8: addresses outside the legacy area are never claimed
  a_r8_outside_none : assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !anyWin) |=> tgtSel == TGT_NONE);

  // R5: open window exposes DRAM
  a_r5_open_dram : assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && smramWin && openQ) |=> tgtSel == TGT_DRAM);

  // R6: SMM with SMRAM enabled sees DRAM
  a_r6_smm_dram : assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && smramWin && cpuSmm && smmEnQ) |=> tgtSel == TGT_DRAM);

  // R9: SMRAM shadow follows the posted control value
  a_r9_shadow_follows : assert property (@(posedge clk) disable iff (!rstN)
    refresh.refreshSmram |=> (openQ == $past(openBit)) && (smmEnQ == $past(smmBit)));

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
  import lwd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CFG_AW      = 8,
  parameter int unsigned NUM_REGIONS = 13,
  parameter int unsigned SEG_SHIFT   = 14,
  parameter logic [CFG_AW-1:0] ATTR_BASE   = 'h59,
  parameter logic [CFG_AW-1:0] SMRAM_OFF   = 'h72,
  parameter logic [7:0]        SMRAM_RESET = 8'h02,
  parameter int unsigned       DOPEN_BIT   = 6,
  parameter int unsigned       GSMRAME_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              cpuSmm,
  output logic [1:0]        tgtSel
);

  refresh_s               refresh;
  logic [NUM_REGIONS-1:0] regionRd, regionWr;
  logic                   openBit, smmBit;
  tgt_e                   tgtInt;

  lwd_cfg_ctrl #(
    .CFG_AW      (CFG_AW),
    .NUM_REGIONS (NUM_REGIONS),
    .ATTR_BASE   (ATTR_BASE),
    .SMRAM_OFF   (SMRAM_OFF),
    .SMRAM_RESET (SMRAM_RESET),
    .DOPEN_BIT   (DOPEN_BIT),
    .GSMRAME_BIT (GSMRAME_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgRdEn   (cfgRdEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .refresh   (refresh),
    .regionRd  (regionRd),
    .regionWr  (regionWr),
    .openBit   (openBit),
    .smmBit    (smmBit)
  );

  lwd_route_dp #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .SEG_SHIFT   (SEG_SHIFT),
    .OPEN_RESET  (SMRAM_RESET[DOPEN_BIT]),
    .SMMEN_RESET (SMRAM_RESET[GSMRAME_BIT])
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .refresh  (refresh),
    .regionRd (regionRd),
    .regionWr (regionWr),
    .openBit  (openBit),
    .smmBit   (smmBit),
    .cpuValid (cpuValid),
    .cpuAddr  (cpuAddr),
    .cpuWrite (cpuWrite),
    .cpuSmm   (cpuSmm),
    .tgtSel   (tgtInt)
  );

  assign tgtSel = tgtInt;

endmodule

// File: tb/legacy_window_decoder_test.sv
`timescale 1ns/1ps
module legacy_window_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [7:0]  cfgAddr = '0, cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0, cpuSmm = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [1:0]  tgtSel;

  always #2.5 clk = ~clk;

  legacy_window_decoder uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cpuValid(cpuValid), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuSmm(cpuSmm), .tgtSel(tgtSel)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] mAttr [7];
  logic [7:0] mSmram;

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int expTgt(input logic [31:0] a, input bit wr, input bit smm);
    int r;
    logic [3:0] nib;
    if (a >= 32'hA0000 && a <= 32'hBFFFF)
      return (mSmram[6] || (smm && mSmram[3])) ? 1 : 2;
    if (a >= 32'hF0000 && a <= 32'hFFFFF) r = 0;
    else if (a >= 32'hC0000 && a < 32'hF0000) r = int'((a - 32'hC0000) / 32'h4000) + 1;
    else return 0;
    if (r == 0)          nib = mAttr[0][7:4];
    else if (r % 2 == 1) nib = mAttr[(r + 1) / 2][3:0];
    else                 nib = mAttr[r / 2][7:4];
    return (wr ? nib[1] : nib[0]) ? 1 : 2;
  endfunction

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a >= 8'h59 && a <= 8'h5F) mAttr[a - 8'h59] = d;
    if (a == 8'h72) mSmram = d;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfgRdEn = 1'b1; cfgAddr = a;
    @(negedge clk);
    cfgRdEn = 1'b0;
    d = cfgRdData;
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input bit smm, output int t);
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = a; cpuWrite = wr; cpuSmm = smm;
    @(negedge clk);
    t = int'(tgtSel);
    cpuValid = 1'b0;
  endtask

  task automatic checkAccess(input string tag, input logic [31:0] a, input bit wr, input bit smm);
    int t;
    access(a, wr, smm, t);
    check($sformatf("%s addr=%h wr=%0d smm=%0d", tag, a, wr, smm), t, expTgt(a, wr, smm));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int t;
    for (int k = 0; k < 7; k++) mAttr[k] = 8'h00;
    mSmram = 8'h02;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset values and reset decode
    cfgRead(8'h72, rd); check("R1 smram reset", rd, 8'h02);
    for (int k = 0; k < 7; k++) begin
      cfgRead(8'h59 + 8'(k), rd); check("R1 attr reset", rd, 0);
    end
    access(32'hC0000, 0, 0, t); check("R1 region read PCI", t, 2);
    access(32'hFFFFF, 1, 1, t); check("R1 bios write PCI", t, 2);
    access(32'hA0000, 0, 0, t); check("R1 window PCI", t, 2);
    access(32'hBFFFF, 0, 1, t); check("R1 smm window PCI", t, 2);

    // R8: idle cycle drives none
    @(negedge clk); check("R8 idle none", int'(tgtSel), 0);

    // R2: readback of mapped bytes
    for (int k = 0; k < 7; k++) begin
      cfgWrite(8'h59 + 8'(k), 8'h3C + 8'(k * 17));
      cfgRead(8'h59 + 8'(k), rd); check("R2 attr readback", rd, 8'h3C + 8'(k * 17));
    end
    cfgWrite(8'h72, 8'hB5); cfgRead(8'h72, rd); check("R2 smram readback", rd, 8'hB5);

    // R3 R4 R7: attribute sweep over four nibble patterns
    for (int p = 0; p < 4; p++) begin
      logic [3:0] nib [13];
      for (int i = 0; i < 13; i++) nib[i] = {2'(p), 2'((i + p) % 4)};
      cfgWrite(8'h59, {nib[0], 4'h5});
      for (int k = 1; k < 7; k++) cfgWrite(8'h59 + 8'(k), {nib[2*k], nib[2*k-1]});
      @(negedge clk);
      for (int i = 0; i < 13; i++) begin
        logic [31:0] lo, hi;
        lo = (i == 0) ? 32'hF0000 : 32'hC0000 + 32'(i - 1) * 32'h4000;
        hi = (i == 0) ? 32'hFFFFF : lo + 32'h3FFF;
        for (int w = 0; w < 2; w++) begin
          checkAccess("R3 R4 region lo", lo, w[0], 1'b0);
          checkAccess("R3 R4 region hi", hi, w[0], 1'b0);
          checkAccess("R7 smm region lo", lo, w[0], 1'b1);
          checkAccess("R7 smm region hi", hi, w[0], 1'b1);
        end
      end
    end

    // R5 R6: SMRAM control sweep with junk bits
    for (int s = 0; s < 16; s++) begin
      logic [7:0] v;
      v = (s[0] ? 8'h40 : 8'h00) | (s[1] ? 8'h08 : 8'h00) |
          (s[2] ? 8'h80 : 8'h00) | (s[3] ? 8'h02 : 8'h00);
      cfgWrite(8'h72, v);
      @(negedge clk);
      for (int w = 0; w < 2; w++) begin
        checkAccess("R5 window non-smm", 32'hA0000, w[0], 1'b0);
        checkAccess("R5 window non-smm top", 32'hBFFFF, w[0], 1'b0);
        checkAccess("R6 window smm", 32'hA0000, w[0], 1'b1);
        checkAccess("R6 window smm top", 32'hBFFFF, w[0], 1'b1);
      end
    end

    // R2: unmapped offsets ignored and read zero
    cfgWrite(8'h59, 8'h03);
    cfgWrite(8'h72, 8'h00);
    @(negedge clk);
    begin
      logic [7:0] junkOff [4];
      junkOff[0] = 8'h58; junkOff[1] = 8'h60; junkOff[2] = 8'h71; junkOff[3] = 8'h73;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); cfgWrEn = 1'b1; cfgAddr = junkOff[k]; cfgWrData = 8'hFF;
        @(negedge clk); cfgWrEn = 0;
        cfgRead(junkOff[k], rd); check("R2 unmapped reads zero", rd, 0);
      end
    end
    cfgRead(8'h59, rd); check("R2 attr kept", rd, 8'h03);
    cfgRead(8'h72, rd); check("R2 smram kept", rd, 0);
    checkAccess("R2 region0 unchanged", 32'hF8000, 1'b0, 1'b0);
    checkAccess("R2 region12 unchanged", 32'hEC000, 1'b1, 1'b0);
    checkAccess("R2 window unchanged", 32'hA8000, 1'b0, 1'b1);

    // R8: outside addresses
    checkAccess("R8 below window", 32'h9FFFF, 1'b0, 1'b0);
    checkAccess("R8 above 1MiB", 32'h100000, 1'b1, 1'b0);
    checkAccess("R8 zero", 32'h0, 1'b0, 1'b1);
    checkAccess("R8 aliased high", 32'h100C0000, 1'b0, 1'b0);
    checkAccess("R8 all ones", 32'hFFFFFFFF, 1'b1, 1'b1);

    // R9: access in the cycle right after a write sees old settings
    cfgWrite(8'h5A, 8'h00);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h5A; cfgWrData = 8'h01;
    @(negedge clk);
    cfgWrEn = 1'b0;
    cpuValid = 1'b1; cpuAddr = 32'hC0000; cpuWrite = 1'b0; cpuSmm = 1'b0;
    @(negedge clk); check("R9 stale decode", int'(tgtSel), 2);
    @(negedge clk); check("R9 new decode", int'(tgtSel), 1);
    cpuValid = 1'b0;
    @(negedge clk); check("R9 registered drop", int'(tgtSel), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule